// File: doc/BRIEF.md
# Peripheral Bus Timeout Monitor

This block watches a shared peripheral bus on which one master at a time drives a select line, and slaves answer with a transfer acknowledge or a retry. If no answer arrives within a fixed number of cycles after select goes high, the block raises a one-cycle timeout pulse to the master. The slave-side inputs are the OR of the matching signals across all slaves.

A slave that needs more time raises a hold-off (timeout suppress) line. While that line is high the counter stays at zero, and the line may stay high for any length of time. When it falls with select still high, counting starts again from zero. If the master drops select before any answer, the transfer counts as aborted and no timeout follows. A hold-off line that lingers for a cycle after an abort, with select low, does nothing. The window length `LIMIT` is a parameter, 16 by default. Parameter `HOLD_EN` chooses, at elaboration, whether the hold-off line is honoured.

Top module: `bus_timeout_mon`

## Requirements
- R1: While `rst` is high (synchronous, active high), the counter clears. In the cycle after a reset edge, `bus_timeout` is 0.
- R2: Let select be high for `LIMIT` consecutive cycles with no acknowledge, no retry and no hold-off, counted from the first cycle select is high. Then `bus_timeout` is 1 in the cycle that follows the `LIMIT`-th such cycle.
- R3: An acknowledge in any of those `LIMIT` cycles, including the last one, prevents the timeout.
- R4: A retry in any of those `LIMIT` cycles, including the last one, prevents the timeout.
- R5: While hold-off is high and select is high, no timeout is raised, however long hold-off stays high.
- R6: When hold-off falls while select stays high, the count restarts from zero. The timeout follows `LIMIT` quiet cycles after the release.
- R7: If select drops before any response, no timeout follows. The next assertion of select starts a fresh count of `LIMIT` cycles.
- R8: Hold-off high while select is low has no effect. A transfer that starts right after it still times out after exactly `LIMIT` quiet cycles.
- R9: The timeout is a single-cycle pulse. It does not repeat while select stays high without a response, even across later hold-off periods.
- R10: A hold-off first raised after the `LIMIT`-th quiet cycle does not prevent the timeout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| bus_sel | input | 1 | Bus select from the active master |
| slv_ack | input | 1 | OR of all slave transfer acknowledges |
| slv_retry | input | 1 | OR of all slave retries |
| slv_hold | input | 1 | OR of all slave timeout-suppress lines |
| bus_timeout | output | 1 | One-cycle timeout pulse |

## Verification
The checker tests a set of properties on every cycle. A pulse is always preceded by a quiet cycle and by a full run of `LIMIT` quiet cycles. No pulse follows a cycle with select low or with a response. The pulse never lasts two cycles, and reset forces the output low. Only the bench's scenarios show that the pulse does arrive on time, and that the count restarts after a hold-off release or an abort. They also show that a late hold-off cannot stop a pulse and that no second pulse follows a long hold-off. The bench checks these against a behavioural model on every clock.

// File: rtl/bus_timeout_pkg.sv
package bus_timeout_pkg;
   // Width needed to hold values 0..n inclusive
   function automatic int unsigned cnt_width(input int unsigned n);
      int unsigned w;
      w = 1;
      while ((2 ** w) <= n) w++;
      return w;
   endfunction
endpackage

// File: rtl/bus_timeout_qual.sv
module bus_timeout_qual #(
   parameter bit HOLD_EN = 1'b1
) (
   input  logic bus_sel,
   input  logic slv_ack,
   input  logic slv_retry,
   input  logic slv_hold,
   output logic xfer_end,
   output logic quiet
);
   logic responded;

   assign responded = slv_ack | slv_retry;
   // A transfer ends when the master releases select or a slave answers
   assign xfer_end  = ~bus_sel | responded;

   generate
      if (HOLD_EN) begin : g_hold
         assign quiet = ~xfer_end & ~slv_hold;
      end else begin : g_nohold
         assign quiet = ~xfer_end;
      end
   endgenerate
endmodule

// File: rtl/bus_timeout_cnt.sv
module bus_timeout_cnt
   import bus_timeout_pkg::*;
#(
   parameter int unsigned LIMIT = 16
) (
   input  logic clk,
   input  logic rst,
   input  logic quiet,
   output logic hit
);
   localparam int unsigned CW = cnt_width(LIMIT);
   localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);
   localparam logic [CW-1:0] TOP  = CW'(LIMIT);

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (rst || !quiet) begin
         cnt_q <= '0;
      end else if (cnt_q != TOP) begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   // The current quiet cycle is the LIMIT-th in a row
   assign hit = quiet && (cnt_q == LAST);
endmodule

// File: rtl/bus_timeout_shot.sv
module bus_timeout_shot (
   input  logic clk,
   input  logic rst,
   input  logic xfer_end,
   input  logic hit,
   output logic pulse
);
   logic fired_q;
   logic pulse_q;

   always_ff @(posedge clk) begin
      if (rst || xfer_end) begin
         fired_q <= 1'b0;
         pulse_q <= 1'b0;
      end else begin
         pulse_q <= hit & ~fired_q;
         fired_q <= fired_q | hit;
      end
   end

   assign pulse = pulse_q;
endmodule

// File: rtl/bus_timeout_mon.sv
module bus_timeout_mon #(
   parameter int unsigned LIMIT   = 16,
   parameter bit          HOLD_EN = 1'b1
) (
   input  logic clk,
   input  logic rst,
   input  logic bus_sel,
   input  logic slv_ack,
   input  logic slv_retry,
   input  logic slv_hold,
   output logic bus_timeout
);
   generate
      if (LIMIT < 2) begin : g_bad_limit
         $error("bus_timeout_mon: LIMIT must be at least 2");
      end
   endgenerate

   logic xfer_end;
   logic quiet;
   logic hit;

   bus_timeout_qual #(.HOLD_EN(HOLD_EN)) u_qual (
      .bus_sel  (bus_sel),
      .slv_ack  (slv_ack),
      .slv_retry(slv_retry),
      .slv_hold (slv_hold),
      .xfer_end (xfer_end),
      .quiet    (quiet)
   );

   bus_timeout_cnt #(.LIMIT(LIMIT)) u_cnt (
      .clk  (clk),
      .rst  (rst),
      .quiet(quiet),
      .hit  (hit)
   );

   bus_timeout_shot u_shot (
      .clk     (clk),
      .rst     (rst),
      .xfer_end(xfer_end),
      .hit     (hit),
      .pulse   (bus_timeout)
   );
endmodule

// File: rtl/bus_timeout_mon_chk.sv
module bus_timeout_mon_chk #(
   parameter int unsigned LIMIT   = 16,
   parameter bit          HOLD_EN = 1'b1
) (
   input logic clk,
   input logic rst,
   input logic bus_sel,
   input logic slv_ack,
   input logic slv_retry,
   input logic slv_hold,
   input logic bus_timeout
);
   logic calm;
   int unsigned run;

   assign calm = bus_sel && !slv_ack && !slv_retry && !(HOLD_EN && slv_hold);

   // Independent run length of quiet cycles, saturating
   always_ff @(posedge clk) begin
      if (rst || !calm) run <= 0;
      else if (run < LIMIT) run <= run + 1;
   end

   assert_reset_low_R1: assert property (@(posedge clk) rst |=> !bus_timeout);

   assert_after_quiet_R2: assert property (@(posedge clk) disable iff (rst)
      bus_timeout |-> $past(calm));

   assert_resp_blocks_R3: assert property (@(posedge clk) disable iff (rst)
      (slv_ack || slv_retry) |=> !bus_timeout); // also R4

   assert_full_run_R6: assert property (@(posedge clk) disable iff (rst)
      bus_timeout |-> (run == LIMIT)); // also R5

   assert_abort_none_R7: assert property (@(posedge clk) disable iff (rst)
      !bus_sel |=> !bus_timeout);

   assert_single_R9: assert property (@(posedge clk) disable iff (rst)
      bus_timeout |=> !bus_timeout);
endmodule

bind bus_timeout_mon bus_timeout_mon_chk #(.LIMIT(LIMIT), .HOLD_EN(HOLD_EN)) u_chk (
   .clk        (clk),
   .rst        (rst),
   .bus_sel    (bus_sel),
   .slv_ack    (slv_ack),
   .slv_retry  (slv_retry),
   .slv_hold   (slv_hold),
   .bus_timeout(bus_timeout)
);

// File: tb/bus_timeout_mon_tb.sv
`timescale 1ns/1ps
module bus_timeout_mon_tb;
   localparam int LIMIT = 16;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic sel = 1'b0, ack = 1'b0, rty = 1'b0, hold = 1'b0;
   logic tmo;

   int errors = 0;
   int checks = 0;
   int cycles = 0;
   string cur_req = "R1";

   // behavioural reference state
   int  m_quiet = 0;
   bit  m_fired = 0;
   bit  m_exp   = 0;
   int  pulses  = 0;
   int  step_no = 0;
   int  pulse_at = -1;

   always #4 clk = ~clk; // 125 MHz

   bus_timeout_mon #(.LIMIT(LIMIT)) u_dut (
      .clk(clk), .rst(rst), .bus_sel(sel), .slv_ack(ack),
      .slv_retry(rty), .slv_hold(hold), .bus_timeout(tmo)
   );

   task automatic check(input string req, input logic act, input logic exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s step %0d: bus_timeout=%0b expected %0b", req, step_no, act, exp);
      end
   endtask

   task automatic check_int(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: got %0d expected %0d", req, act, exp);
      end
   endtask

   // Apply one cycle of inputs, advance the model, compare after the edge
   task automatic step(input bit r, input bit s, input bit a, input bit t, input bit h);
      @(negedge clk);
      rst = r; sel = s; ack = a; rty = t; hold = h;
      @(posedge clk);
      #1;
      step_no++;
      if (r || !s || a || t) begin
         m_quiet = 0; m_fired = 0; m_exp = 0;
      end else if (h) begin
         m_quiet = 0; m_exp = 0;
      end else begin
         if (m_quiet < LIMIT) m_quiet++;
         m_exp = (m_quiet == LIMIT) && !m_fired;
         if (m_exp) m_fired = 1;
      end
      check(cur_req, tmo, m_exp);
      if (tmo === 1'b1) begin
         pulses++;
         if (pulse_at < 0) pulse_at = step_no;
      end
   endtask

   task automatic start_scn(input string req);
      cur_req = req;
      for (int i = 0; i < 2; i++) step(0, 0, 0, 0, 0);
      pulses = 0; step_no = 0; pulse_at = -1;
   endtask

   initial begin : watchdog
      while (cycles < 100000) begin
         @(posedge clk);
         cycles++;
      end
      errors++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin : stim
      // R1: reset
      cur_req = "R1";
      for (int i = 0; i < 3; i++) step(1, 1, 0, 0, 0);
      check("R1", tmo, 1'b0);

      // R2: quiet transfer, pulse after LIMIT cycles (step LIMIT+1 sees it at step LIMIT)
      start_scn("R2");
      for (int i = 0; i < LIMIT + 10; i++) step(0, 1, 0, 0, 0);
      check_int("R2 pulse step", pulse_at, LIMIT);
      // R9: no repeat while select stays high
      check_int("R9 single pulse", pulses, 1);

      // R3: ack in last cycle of window
      start_scn("R3");
      for (int i = 0; i < LIMIT - 1; i++) step(0, 1, 0, 0, 0);
      step(0, 1, 1, 0, 0);
      for (int i = 0; i < 4; i++) step(0, 0, 0, 0, 0);
      check_int("R3 no pulse", pulses, 0);

      // R4: retry in last cycle, and retry mid window
      start_scn("R4");
      for (int i = 0; i < LIMIT - 1; i++) step(0, 1, 0, 0, 0);
      step(0, 1, 0, 1, 0);
      step(0, 0, 0, 0, 0);
      for (int i = 0; i < 9; i++) step(0, 1, 0, 0, 0);
      step(0, 1, 0, 1, 0);
      step(0, 0, 0, 0, 0);
      check_int("R4 no pulse", pulses, 0);

      // R5: long hold-off, then R6: release restarts count
      start_scn("R5");
      for (int i = 0; i < 4; i++) step(0, 1, 0, 0, 0);
      for (int i = 0; i < 3 * LIMIT; i++) step(0, 1, 0, 0, 1);
      check_int("R5 no pulse under hold", pulses, 0);
      cur_req = "R6";
      step_no = 0;
      for (int i = 0; i < LIMIT + 3; i++) step(0, 1, 0, 0, 0);
      check_int("R6 pulse after release", pulse_at, LIMIT);
      check_int("R6 pulse count", pulses, 1);
      // R9: hold-off then release again after the pulse gives no second pulse
      cur_req = "R9";
      for (int i = 0; i < 3; i++) step(0, 1, 0, 0, 1);
      for (int i = 0; i < LIMIT + 4; i++) step(0, 1, 0, 0, 0);
      check_int("R9 no repeat after hold", pulses, 1);
      step(0, 1, 1, 0, 0);

      // R7: abort at cycle 12 then fresh transfer
      start_scn("R7");
      for (int i = 0; i < 12; i++) step(0, 1, 0, 0, 0);
      step(0, 0, 0, 0, 0);
      check_int("R7 no pulse after abort", pulses, 0);
      step_no = 0;
      for (int i = 0; i < LIMIT + 2; i++) step(0, 1, 0, 0, 0);
      check_int("R7 fresh count", pulse_at, LIMIT);
      step(0, 1, 1, 0, 0);

      // R8: hold-off lingers with select low after abort
      start_scn("R8");
      for (int i = 0; i < 14; i++) step(0, 1, 0, 0, 1);
      step(0, 0, 0, 0, 1);
      check_int("R8 no pulse on abort", pulses, 0);
      step_no = 0;
      for (int i = 0; i < LIMIT + 2; i++) step(0, 1, 0, 0, 0);
      check_int("R8 full window after linger", pulse_at, LIMIT);
      step(0, 1, 1, 0, 0);

      // R10: hold-off raised only after the window has run out
      start_scn("R10");
      for (int i = 0; i < LIMIT; i++) step(0, 1, 0, 0, 0);
      step(0, 1, 0, 0, 1);
      for (int i = 0; i < 3; i++) step(0, 1, 0, 0, 1);
      check_int("R10 late hold", pulses, 1);
      step(0, 0, 0, 0, 0);

      // R1: reset mid-transfer clears the count
      start_scn("R1");
      for (int i = 0; i < 10; i++) step(0, 1, 0, 0, 0);
      step(1, 1, 0, 0, 0);
      check("R1", tmo, 1'b0);
      step_no = 0;
      for (int i = 0; i < LIMIT + 1; i++) step(0, 1, 0, 0, 0);
      check_int("R1 count cleared by reset", pulse_at, LIMIT);

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule